// File: doc/BRIEF.md
# Ping-Pong Endpoint Packet Buffer

This block holds the packet data of one USB device endpoint. Each direction has two banks that alternate. In the transmit direction, firmware writes bytes into the fill bank. A bank becomes ready for the bus when one of three things happens:

- its byte count reaches the configured maximum packet size,
- firmware issues an explicit validate strobe,
- firmware writes a packet length.

The bus-side packet engine reads the ready banks byte by byte. It acknowledges each packet with a done strobe, which frees the bank. The banks go out in the order they became ready.

In the receive direction, the bus engine writes bytes into a fill bank and commits the packet. Firmware then reads the packet, and the bank frees itself when the last byte has been read.

A single clear strobe empties one bank per pulse, on the side selected by the direction input. Emptying both banks of a direction takes two pulses. Firmware writes into a transmit bank that is already waiting are dropped, and an error pulse is raised. Token decoding, CRC and register decode belong to the surrounding logic. The maximum packet size must lie between 1 and the bank depth, and it is changed only while both directions are empty.

Top module: `ep_pingpong_buf`

## Requirements
- R1: A firmware byte write stores the byte in the transmit fill bank. The bus side reads the head packet in write order through `bus_tx_data`, and each `bus_tx_pop` advances to the next byte.
- R2: When a transmit bank's count reaches `cfg_mps`, the bank becomes ready on the same clock edge as the write that completes it. Later writes go to the other bank.
- R3: `fw_validate` makes the transmit fill bank ready with the bytes written so far, including zero bytes, which gives a zero-length packet.
- R4: `fw_len_wr` makes the transmit fill bank ready with length min(`fw_len`, `cfg_mps`).
- R5: Ready transmit banks are offered in the order they became ready. `bus_tx_done` frees the head bank, and the other ready bank, if any, becomes the head.
- R6: `bus_tx_ready` is 0 whenever no transmit bank is ready, and it is 0 after reset.
- R7: A firmware write while both transmit banks are ready is dropped, and `fw_wr_err` is 1 for exactly the following cycle. Otherwise `fw_wr_err` is 0.
- R8: Bus receive bytes fill the receive bank up to `cfg_mps`, and further bytes are dropped. `bus_rx_commit` hands the bank to firmware, which reads its bytes in order through `fw_rd_data`, `fw_rx_avail` and `fw_rx_len`.
- R9: A receive bank is freed on the edge where firmware reads its last byte. A committed zero-length bank is freed one cycle after it becomes the head.
- R10: `bus_rx_ready` is 0 while both receive banks hold committed packets, and bus writes and commits are ignored during that time.
- R11: `fw_clear` with `cfg_dir_in`=1 frees only the head ready transmit bank. When no transmit bank is ready, it empties the partly written fill bank instead.
- R12: `fw_clear` with `cfg_dir_in`=0 frees only the head committed receive bank. When no receive bank is committed, it discards the partly received bytes instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_mps | input | CW | Maximum packet size in bytes (1..DEPTH) |
| cfg_dir_in | input | 1 | Clear target: 1 transmit, 0 receive |
| fw_wr_en | input | 1 | Firmware transmit byte write |
| fw_wr_data | input | 8 | Firmware transmit byte |
| fw_validate | input | 1 | Make the transmit fill bank ready |
| fw_len_wr | input | 1 | Make the fill bank ready with a given length |
| fw_len | input | CW | Length used with `fw_len_wr` |
| fw_clear | input | 1 | Free or empty one bank |
| fw_wr_err | output | 1 | Write hit a full pair of ready banks |
| fw_rd_en | input | 1 | Firmware receive byte read |
| fw_rd_data | output | 8 | Current receive byte |
| fw_rx_avail | output | 1 | A committed receive packet is at the head |
| fw_rx_len | output | CW | Length of the head receive packet |
| bus_tx_pop | input | 1 | Advance to the next transmit byte |
| bus_tx_done | input | 1 | Head transmit packet acknowledged |
| bus_tx_data | output | 8 | Current transmit byte |
| bus_tx_len | output | CW | Length of the head transmit packet |
| bus_tx_ready | output | 1 | A transmit packet is ready |
| bus_rx_wr | input | 1 | Bus receive byte write |
| bus_rx_data | input | 8 | Bus receive byte |
| bus_rx_commit | input | 1 | End of the received packet |
| bus_rx_ready | output | 1 | A receive bank can take data |

## Verification
The assertions check the following on every cycle:

- the not-ready indications against the internal ready and full bank flags,
- the error pulse after a write into two ready banks, and its absence without a write,
- that the head bank alternates on each acknowledged packet,
- that neither head length exceeds the maximum packet size.

Byte order across banks, the three ways a transmit bank becomes ready, the moment a receive bank is freed (including zero-length packets), and the one-bank-per-pulse effect of the clear strobe can be shown only by the bench's scenarios. There, a queue-based model follows every cycle.

// File: rtl/ep_pp_pkg.sv
// Shared types for the ping-pong endpoint buffer.
package ep_pp_pkg;
    localparam int BYTE_W = 8;
    typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/pp_bank_mem.sv
// Two-bank byte store with one write port and one combinational read port.
// Assumes DEPTH is a power of two; the bank select is the top address bit.
module pp_bank_mem
    import ep_pp_pkg::*;
#(
    parameter int DEPTH = 512,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic          wr_bank,
    input  logic [AW-1:0] wr_addr,
    input  byte_t         wr_data,
    input  logic          rd_bank,
    input  logic [AW-1:0] rd_addr,
    output byte_t         rd_data
);
    byte_t store [2*DEPTH];

    // Write one byte into the selected bank.
    always_ff @(posedge clk) begin
        if (wr_en) store[{wr_bank, wr_addr}] <= wr_data;
    end

    // Present the byte at the read pointer.
    assign rd_data = store[{rd_bank, rd_addr}];
endmodule

// File: rtl/tx_pp_ctrl.sv
// Transmit bank control: firmware fills one bank while the other waits.
// A bank becomes ready when full, on the validate strobe, or on a length write.
// Ready banks are handed out in order; a done strobe or a clear frees the head.
// Assumes mps is in 1..DEPTH and only changes while no bank holds data.
module tx_pp_ctrl #(
    parameter int DEPTH = 512,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] mps,
    input  logic          wr_en,
    input  logic          validate,
    input  logic          len_wr,
    input  logic [CW-1:0] len_val,
    input  logic          clear,
    input  logic          send_pop,
    input  logic          send_done,
    output logic          mem_we,
    output logic          mem_wbank,
    output logic [AW-1:0] mem_waddr,
    output logic          mem_rbank,
    output logic [AW-1:0] mem_raddr,
    output logic          wr_err,
    output logic [1:0]    vld,
    output logic          rsel,
    output logic [CW-1:0] head_len
);
    logic          wsel;
    logic [CW-1:0] cnt [2];
    logic [AW-1:0] rptr;
    logic          fill_free, clr_fill, wr_ok, seal, release_head;
    logic [CW-1:0] cnt_after, seal_len;

    // Decide this cycle's fill, seal and release actions.
    always_comb begin
        fill_free    = !vld[wsel];
        release_head = vld[rsel] && (send_done || clear);
        clr_fill     = clear && !vld[rsel];
        wr_ok        = wr_en && fill_free && (cnt[wsel] < mps) && !clr_fill;
        cnt_after    = cnt[wsel] + CW'(wr_ok);
        seal         = fill_free && !clr_fill &&
                       (validate || len_wr || (wr_ok && (cnt_after == mps)));
        seal_len     = len_wr ? ((len_val > mps) ? mps : len_val) : cnt_after;
    end

    // Update counts, ready flags and the two bank selects.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wsel   <= 1'b0;
            rsel   <= 1'b0;
            vld    <= 2'b00;
            cnt[0] <= '0;
            cnt[1] <= '0;
            rptr   <= '0;
            wr_err <= 1'b0;
        end else begin
            wr_err <= wr_en && !fill_free;
            if (wr_ok) cnt[wsel] <= cnt_after;
            if (seal) begin
                vld[wsel] <= 1'b1;
                cnt[wsel] <= seal_len;
                wsel      <= ~wsel;
            end
            if (clr_fill) cnt[wsel] <= '0;
            if (release_head) begin
                vld[rsel] <= 1'b0;
                cnt[rsel] <= '0;
                rsel      <= ~rsel;
                rptr      <= '0;
            end else if (send_pop && vld[rsel]) begin
                rptr <= rptr + AW'(1);
            end
        end
    end

    assign mem_we    = wr_ok;
    assign mem_wbank = wsel;
    assign mem_waddr = cnt[wsel][AW-1:0];
    assign mem_rbank = rsel;
    assign mem_raddr = rptr;
    assign head_len  = cnt[rsel];
endmodule

// File: rtl/rx_pp_ctrl.sv
// Receive bank control: the bus fills one bank while firmware drains the other.
// A commit hands the bank to firmware; reading its last byte, a clear, or a
// zero length frees it. Bytes beyond mps are dropped.
// Assumes mps is in 1..DEPTH and only changes while no bank holds data.
module rx_pp_ctrl #(
    parameter int DEPTH = 512,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] mps,
    input  logic          bus_wr,
    input  logic          bus_commit,
    input  logic          fw_rd,
    input  logic          clear,
    output logic          mem_we,
    output logic          mem_wbank,
    output logic [AW-1:0] mem_waddr,
    output logic          mem_rbank,
    output logic [AW-1:0] mem_raddr,
    output logic [1:0]    full,
    output logic          head_avail,
    output logic [CW-1:0] head_len,
    output logic          bus_ready
);
    logic          wsel, rsel;
    logic [CW-1:0] cnt [2];
    logic [CW-1:0] rptr;
    logic          fill_free, clr_fill, wr_ok, seal, rd_ok, release_head;

    // Decide this cycle's fill, commit, read and release actions.
    always_comb begin
        fill_free    = !full[wsel];
        clr_fill     = clear && !full[rsel];
        wr_ok        = bus_wr && fill_free && (cnt[wsel] < mps) && !clr_fill;
        seal         = bus_commit && fill_free && !clr_fill;
        rd_ok        = fw_rd && full[rsel] && (rptr < cnt[rsel]);
        release_head = full[rsel] && (clear || (cnt[rsel] == '0) ||
                       (rd_ok && ((rptr + CW'(1)) == cnt[rsel])));
    end

    // Update counts, full flags, selects and the read pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wsel   <= 1'b0;
            rsel   <= 1'b0;
            full   <= 2'b00;
            cnt[0] <= '0;
            cnt[1] <= '0;
            rptr   <= '0;
        end else begin
            if (wr_ok) cnt[wsel] <= cnt[wsel] + CW'(1);
            if (seal) begin
                full[wsel] <= 1'b1;
                wsel       <= ~wsel;
            end
            if (clr_fill) cnt[wsel] <= '0;
            if (release_head) begin
                full[rsel] <= 1'b0;
                cnt[rsel]  <= '0;
                rsel       <= ~rsel;
                rptr       <= '0;
            end else if (rd_ok) begin
                rptr <= rptr + CW'(1);
            end
        end
    end

    assign mem_we     = wr_ok;
    assign mem_wbank  = wsel;
    assign mem_waddr  = cnt[wsel][AW-1:0];
    assign mem_rbank  = rsel;
    assign mem_raddr  = rptr[AW-1:0];
    assign head_avail = full[rsel];
    assign head_len   = cnt[rsel];
    assign bus_ready  = fill_free;
endmodule

// File: rtl/ep_pingpong_buf.sv
// Endpoint packet buffer with two ping-pong banks per direction.
// Joins the transmit and receive controls to one byte store each and routes
// the shared clear strobe by cfg_dir_in. All outputs come from registers.
module ep_pingpong_buf
    import ep_pp_pkg::*;
#(
    parameter int DEPTH = 512,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] cfg_mps,
    input  logic          cfg_dir_in,
    input  logic          fw_wr_en,
    input  logic [7:0]    fw_wr_data,
    input  logic          fw_validate,
    input  logic          fw_len_wr,
    input  logic [CW-1:0] fw_len,
    input  logic          fw_clear,
    output logic          fw_wr_err,
    input  logic          fw_rd_en,
    output logic [7:0]    fw_rd_data,
    output logic          fw_rx_avail,
    output logic [CW-1:0] fw_rx_len,
    input  logic          bus_tx_pop,
    input  logic          bus_tx_done,
    output logic [7:0]    bus_tx_data,
    output logic [CW-1:0] bus_tx_len,
    output logic          bus_tx_ready,
    input  logic          bus_rx_wr,
    input  logic [7:0]    bus_rx_data,
    input  logic          bus_rx_commit,
    output logic          bus_rx_ready
);
    logic          clr_tx, clr_rx;
    logic          tx_we, tx_wbank, tx_rbank;
    logic [AW-1:0] tx_waddr, tx_raddr;
    logic          rx_we, rx_wbank, rx_rbank;
    logic [AW-1:0] rx_waddr, rx_raddr;
    logic [1:0]    tx_vld, rx_full;
    logic          tx_rsel;

    assign clr_tx = fw_clear & cfg_dir_in;
    assign clr_rx = fw_clear & ~cfg_dir_in;

    tx_pp_ctrl #(.DEPTH(DEPTH)) tx_ctrl_i (
        .clk(clk), .rst_n(rst_n), .mps(cfg_mps),
        .wr_en(fw_wr_en), .validate(fw_validate), .len_wr(fw_len_wr),
        .len_val(fw_len), .clear(clr_tx), .send_pop(bus_tx_pop),
        .send_done(bus_tx_done), .mem_we(tx_we), .mem_wbank(tx_wbank),
        .mem_waddr(tx_waddr), .mem_rbank(tx_rbank), .mem_raddr(tx_raddr),
        .wr_err(fw_wr_err), .vld(tx_vld), .rsel(tx_rsel),
        .head_len(bus_tx_len)
    );

    pp_bank_mem #(.DEPTH(DEPTH)) tx_mem_i (
        .clk(clk), .wr_en(tx_we), .wr_bank(tx_wbank), .wr_addr(tx_waddr),
        .wr_data(fw_wr_data), .rd_bank(tx_rbank), .rd_addr(tx_raddr),
        .rd_data(bus_tx_data)
    );

    rx_pp_ctrl #(.DEPTH(DEPTH)) rx_ctrl_i (
        .clk(clk), .rst_n(rst_n), .mps(cfg_mps),
        .bus_wr(bus_rx_wr), .bus_commit(bus_rx_commit), .fw_rd(fw_rd_en),
        .clear(clr_rx), .mem_we(rx_we), .mem_wbank(rx_wbank),
        .mem_waddr(rx_waddr), .mem_rbank(rx_rbank), .mem_raddr(rx_raddr),
        .full(rx_full), .head_avail(fw_rx_avail), .head_len(fw_rx_len),
        .bus_ready(bus_rx_ready)
    );

    pp_bank_mem #(.DEPTH(DEPTH)) rx_mem_i (
        .clk(clk), .wr_en(rx_we), .wr_bank(rx_wbank), .wr_addr(rx_waddr),
        .wr_data(bus_rx_data), .rd_bank(rx_rbank), .rd_addr(rx_raddr),
        .rd_data(fw_rd_data)
    );

    assign bus_tx_ready = tx_vld[tx_rsel];
endmodule

// File: rtl/ep_pingpong_buf_chk.sv
// Property checker for ep_pingpong_buf, attached by bind below.
module ep_pingpong_buf_chk #(
    parameter int CW = 10
) (
    input logic          clk,
    input logic          rst_n,
    input logic [CW-1:0] cfg_mps,
    input logic          fw_wr_en,
    input logic          fw_wr_err,
    input logic          bus_tx_ready,
    input logic          bus_tx_done,
    input logic [CW-1:0] bus_tx_len,
    input logic          fw_rx_avail,
    input logic [CW-1:0] fw_rx_len,
    input logic          bus_rx_ready,
    input logic [1:0]    tx_vld,
    input logic [1:0]    rx_full,
    input logic          tx_rsel
);
    assert_tx_not_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_vld == 2'b00) |-> !bus_tx_ready);

    assert_tx_len_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_tx_ready |-> (bus_tx_len <= cfg_mps));

    assert_err_after_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (fw_wr_en && (tx_vld == 2'b11)) |=> fw_wr_err);

    assert_no_spurious_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !fw_wr_en |=> !fw_wr_err);

    assert_head_alternates_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_tx_done && bus_tx_ready) |=> (tx_rsel != $past(tx_rsel)));

    assert_rx_not_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_full == 2'b11) |-> !bus_rx_ready);

    assert_rx_len_in_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fw_rx_avail |-> (fw_rx_len <= cfg_mps));
endmodule

bind ep_pingpong_buf ep_pingpong_buf_chk #(.CW(CW)) chk_i (.*);

// File: tb/ep_pingpong_buf_tb_top.sv
// Bench: drives both sides, keeps a queue model, compares every cycle.
module ep_pingpong_buf_tb_top;
    localparam int DEPTH = 512;
    localparam int CW = $clog2(DEPTH + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [CW-1:0] cfg_mps = CW'(4);
    logic          cfg_dir_in = 1'b1;
    logic          fw_wr_en = 1'b0, fw_validate = 1'b0, fw_len_wr = 1'b0;
    logic          fw_clear = 1'b0, fw_rd_en = 1'b0;
    logic [7:0]    fw_wr_data = '0, bus_rx_data = '0;
    logic [CW-1:0] fw_len = '0;
    logic          bus_tx_pop = 1'b0, bus_tx_done = 1'b0;
    logic          bus_rx_wr = 1'b0, bus_rx_commit = 1'b0;
    logic          fw_wr_err, fw_rx_avail, bus_tx_ready, bus_rx_ready;
    logic [7:0]    fw_rd_data, bus_tx_data;
    logic [CW-1:0] fw_rx_len, bus_tx_len;

    always #5 clk = ~clk;

    ep_pingpong_buf #(.DEPTH(DEPTH)) dut_i (.*);

    int    checks = 0;
    int    fails = 0;
    int    cycles = 0;
    string cur_req = "R6";

    // Reference model state.
    logic [7:0] tf[$], tp_dat[$], rf[$], rp_dat[$];
    int         tp_len[$], rp_len[$];
    int         trd = 0, rrd = 0;
    bit         err_exp = 1'b0;

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", cur_req, what, act, exp);
        end
    endtask

    // Model update on each rising edge from the same inputs the design sees.
    always @(posedge clk) begin
        int  n, rn, l;
        bit  rel, clrf;
        if (!rst_n) begin
            tf.delete(); tp_dat.delete(); tp_len.delete();
            rf.delete(); rp_dat.delete(); rp_len.delete();
            trd = 0; rrd = 0; err_exp = 0;
        end else begin
            n = tp_len.size();
            err_exp = fw_wr_en && (n == 2);
            rel  = (n > 0) && (bus_tx_done || (fw_clear && cfg_dir_in));
            clrf = fw_clear && cfg_dir_in && (n == 0);
            if (n < 2 && !clrf) begin
                if (fw_wr_en && tf.size() < int'(cfg_mps)) tf.push_back(fw_wr_data);
                if (fw_len_wr) begin
                    l = (int'(fw_len) > int'(cfg_mps)) ? int'(cfg_mps) : int'(fw_len);
                    tp_len.push_back(l);
                    for (int i = 0; i < l; i++) tp_dat.push_back(tf[i]);
                    tf.delete();
                end else if (fw_validate || (fw_wr_en && tf.size() == int'(cfg_mps))) begin
                    tp_len.push_back(tf.size());
                    foreach (tf[i]) tp_dat.push_back(tf[i]);
                    tf.delete();
                end
            end
            if (clrf) tf.delete();
            if (rel) begin
                for (int i = 0; i < tp_len[0]; i++) void'(tp_dat.pop_front());
                void'(tp_len.pop_front());
                trd = 0;
            end else if (bus_tx_pop && n > 0) trd++;

            rn   = rp_len.size();
            clrf = fw_clear && !cfg_dir_in && (rn == 0);
            rel  = (rn > 0) && ((fw_clear && !cfg_dir_in) || rp_len[0] == 0 ||
                   (fw_rd_en && rrd + 1 == rp_len[0]));
            if (rn < 2 && !clrf) begin
                if (bus_rx_wr && rf.size() < int'(cfg_mps)) rf.push_back(bus_rx_data);
                if (bus_rx_commit) begin
                    rp_len.push_back(rf.size());
                    foreach (rf[i]) rp_dat.push_back(rf[i]);
                    rf.delete();
                end
            end
            if (clrf) rf.delete();
            if (rel) begin
                for (int i = 0; i < rp_len[0]; i++) void'(rp_dat.pop_front());
                void'(rp_len.pop_front());
                rrd = 0;
            end else if (fw_rd_en && rn > 0 && rrd < rp_len[0]) rrd++;
        end
    end

    // Compare registered outputs with the model away from the rising edge.
    always @(negedge clk) begin
        if (rst_n) begin
            chk(bus_tx_ready == (tp_len.size() > 0), "bus_tx_ready",
                int'(bus_tx_ready), int'(tp_len.size() > 0));
            if (tp_len.size() > 0) begin
                chk(int'(bus_tx_len) == tp_len[0], "bus_tx_len", int'(bus_tx_len), tp_len[0]);
                if (trd < tp_len[0])
                    chk(bus_tx_data == tp_dat[trd], "bus_tx_data",
                        int'(bus_tx_data), int'(tp_dat[trd]));
            end
            chk(fw_wr_err == err_exp, "fw_wr_err", int'(fw_wr_err), int'(err_exp));
            chk(bus_rx_ready == (rp_len.size() < 2), "bus_rx_ready",
                int'(bus_rx_ready), int'(rp_len.size() < 2));
            chk(fw_rx_avail == (rp_len.size() > 0), "fw_rx_avail",
                int'(fw_rx_avail), int'(rp_len.size() > 0));
            if (rp_len.size() > 0) begin
                chk(int'(fw_rx_len) == rp_len[0], "fw_rx_len", int'(fw_rx_len), rp_len[0]);
                if (rrd < rp_len[0])
                    chk(fw_rd_data == rp_dat[rrd], "fw_rd_data",
                        int'(fw_rd_data), int'(rp_dat[rrd]));
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 200000) begin
            checks++; fails++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic fw_write(input logic [7:0] d);
        fw_wr_en = 1; fw_wr_data = d; @(negedge clk); fw_wr_en = 0;
    endtask
    task automatic fw_val();
        fw_validate = 1; @(negedge clk); fw_validate = 0;
    endtask
    task automatic fw_setlen(input int l);
        fw_len_wr = 1; fw_len = CW'(l); @(negedge clk); fw_len_wr = 0;
    endtask
    task automatic do_clear(input logic dir);
        cfg_dir_in = dir; fw_clear = 1; @(negedge clk); fw_clear = 0;
    endtask
    task automatic tx_drain();
        int l = tp_len[0];
        for (int i = 0; i < l; i++) begin bus_tx_pop = 1; @(negedge clk); bus_tx_pop = 0; end
        bus_tx_done = 1; @(negedge clk); bus_tx_done = 0;
    endtask
    task automatic rx_send(input int k, input logic [7:0] base, input bit commit);
        for (int i = 0; i < k; i++) begin
            bus_rx_wr = 1; bus_rx_data = base + 8'(i); @(negedge clk); bus_rx_wr = 0;
        end
        if (commit) begin bus_rx_commit = 1; @(negedge clk); bus_rx_commit = 0; end
    endtask
    task automatic fw_read(input int k);
        for (int i = 0; i < k; i++) begin fw_rd_en = 1; @(negedge clk); fw_rd_en = 0; end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R6 / R10: reset state
        chk(!bus_tx_ready, "reset bus_tx_ready", int'(bus_tx_ready), 0);
        cur_req = "R10";
        chk(bus_rx_ready && !fw_rx_avail, "reset rx side", int'(fw_rx_avail), 0);

        // R1, R2: fill to the maximum packet size, ready without a strobe
        cur_req = "R2";
        for (int i = 0; i < 4; i++) fw_write(8'h10 + 8'(i));
        chk(bus_tx_ready && bus_tx_len == 4, "auto ready", int'(bus_tx_len), 4);
        cur_req = "R1";
        tx_drain();

        // R3: early validate, then a zero-length packet
        cur_req = "R3";
        fw_write(8'hA1); fw_write(8'hA2); fw_val();
        chk(bus_tx_len == 2, "partial len", int'(bus_tx_len), 2);
        tx_drain();
        fw_val();
        chk(bus_tx_ready && bus_tx_len == 0, "zero-length ready", int'(bus_tx_len), 0);
        tx_drain();

        // R4: length write validates a shorter packet
        cur_req = "R4";
        fw_write(8'h31); fw_write(8'h32); fw_write(8'h33); fw_setlen(2);
        chk(bus_tx_len == 2, "length write", int'(bus_tx_len), 2);
        tx_drain();

        // R5, R7: two ready banks, overflow write, in-order drain
        cur_req = "R7";
        cfg_mps = CW'(3);
        for (int i = 0; i < 6; i++) fw_write(8'h50 + 8'(i));
        fw_write(8'hEE);
        chk(fw_wr_err, "error pulse", int'(fw_wr_err), 1);
        @(negedge clk);
        chk(!fw_wr_err, "error one cycle", int'(fw_wr_err), 0);
        cur_req = "R5";
        chk(bus_tx_data == 8'h50, "first packet head", int'(bus_tx_data), 'h50);
        tx_drain();
        chk(bus_tx_data == 8'h53, "second packet head", int'(bus_tx_data), 'h53);
        tx_drain();

        // R11: each clear frees one transmit bank, else empties the fill bank
        cur_req = "R11";
        cfg_mps = CW'(4);
        for (int i = 0; i < 4; i++) fw_write(8'h60 + 8'(i));
        fw_write(8'h70); fw_write(8'h71); fw_val();
        do_clear(1);
        chk(bus_tx_ready && bus_tx_len == 2, "one bank cleared", int'(bus_tx_len), 2);
        do_clear(1);
        chk(!bus_tx_ready, "both cleared", int'(bus_tx_ready), 0);
        fw_write(8'h80); fw_write(8'h81); fw_write(8'h82);
        do_clear(1);
        fw_write(8'h90); fw_val();
        chk(bus_tx_len == 1 && bus_tx_data == 8'h90, "fill emptied",
            int'(bus_tx_len), 1);
        tx_drain();

        // R2: largest packet size reaches the top of the bank
        cur_req = "R2";
        cfg_mps = CW'(DEPTH);
        for (int i = 0; i < DEPTH; i++) fw_write(8'(i * 7));
        chk(bus_tx_ready && int'(bus_tx_len) == DEPTH, "full-size ready",
            int'(bus_tx_len), DEPTH);
        tx_drain();
        cfg_mps = CW'(4);

        // R8: receive with a dropped overflow byte
        cur_req = "R8";
        rx_send(5, 8'hC0, 1);
        chk(fw_rx_avail && fw_rx_len == 4, "rx saturated", int'(fw_rx_len), 4);
        // R10: both banks committed, bus side refused
        cur_req = "R10";
        rx_send(2, 8'hD0, 1);
        chk(!bus_rx_ready, "rx not ready", int'(bus_rx_ready), 0);
        rx_send(1, 8'hF0, 1);
        // R9: release on last byte, then the second packet
        cur_req = "R9";
        fw_read(4);
        chk(fw_rx_avail && fw_rx_len == 2 && fw_rd_data == 8'hD0, "next rx head",
            int'(fw_rd_data), 'hD0);
        fw_read(2);
        chk(!fw_rx_avail, "rx empty", int'(fw_rx_avail), 0);
        rx_send(0, 8'h00, 1);
        repeat (2) @(negedge clk);
        chk(!fw_rx_avail, "zero-length freed", int'(fw_rx_avail), 0);

        // R12: each clear frees one receive bank, else drops partial bytes
        cur_req = "R12";
        rx_send(3, 8'h20, 1); rx_send(1, 8'h40, 1);
        do_clear(0);
        chk(fw_rx_avail && fw_rx_len == 1, "one rx cleared", int'(fw_rx_len), 1);
        do_clear(0);
        chk(!fw_rx_avail && bus_rx_ready, "rx both cleared", int'(fw_rx_avail), 0);
        rx_send(2, 8'h11, 0);
        do_clear(0);
        rx_send(1, 8'h77, 1);
        chk(fw_rx_len == 1 && fw_rd_data == 8'h77, "partial dropped",
            int'(fw_rd_data), 'h77);
        fw_read(1);
        repeat (3) @(negedge clk);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule